// File: doc/BRIEF.md
# Programmable Up-Counting Timer Channel

This block is a single timer channel that software drives through a small register bus. An up-counter advances on each enabled tick until it matches a programmable limit. In continuous mode the counter then restarts from zero and keeps producing events. In one-shot mode it freezes and switches itself off. Every match latches a pending flag. The interrupt line is that flag gated by a software enable, and software clears the flag by writing an acknowledge word.

Reset, start and stop are command strobes. A write to their address performs the action, and the written value plays no part. A status word reports the run state, the enable, the mode, the interrupt enable and the pending flag. Software can reprogram the channel for a new event with a fixed sequence: mask the interrupt, stop, reset, load the limit, select the mode, unmask, start.

Top module: `tmr_channel`

## Requirements
- R1: After reset the count reads 0, the limit reads 0, the status reads 0x01 (idle, stopped, continuous, interrupt masked, nothing pending) and `irq` is low.
- R2: A write to byte offset 0x00 clears the count and the pending flag. A write to 0x04 starts the channel and a write to 0x08 stops it. For all three the data value is ignored, and limit, mode and interrupt enable keep their values.
- R3: The count (read at 0x14) rises by exactly one per clock in which `tick_en` is high and the channel is running. Otherwise it holds.
- R4: In continuous mode (bit 0 of a write to 0x0C is 0), a tick that finds the count equal to the limit (read/write at 0x18) sets the pending flag and returns the count to 0. This repeats every limit+1 ticks.
- R5: In one-shot mode (bit 0 written as 1), a tick at the limit sets the pending flag, leaves the count at the limit and stops the channel. Further ticks change nothing.
- R6: Status at 0x10 packs the run state in bits [3:0] (1 idle, 2 running), running in bit 4, one-shot in bit 5, interrupt enable in bit 6 and pending in bit 7. All other bits are 0.
- R7: `irq` is high exactly when the pending flag is set and the interrupt enable (bit 0 of a write to 0x1C) is 1.
- R8: A write to 0x20 with bit 7 set clears the pending flag, and a write without bit 7 leaves it set. If a limit match and an acknowledge fall in the same cycle, the flag ends set.
- R9: Reads of 0x00, 0x04, 0x08, 0x0C, 0x1C, 0x20 and of any unmapped offset return 0.
- R10: The reprogramming sequence always arms a fresh event. Afterwards the count is 0, nothing is pending, and a one-shot event fires on the (limit+1)-th tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Count qualifier, one pulse per timer tick |
| bus_addr | input | 8 | Byte offset of the access |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, valid in the same cycle as `bus_rd`, 0 when idle |
| irq | output | 1 | Interrupt request |

## Verification
The assertions check, on every cycle, the local rules of the counter. A match sets the pending flag. A continuous match returns the count to zero, and a one-shot match stops the channel with its count frozen. Without a qualified tick the count holds. A reset command clears count and flag, and an acknowledge with no match clears the flag. Write-only offsets read zero. Only the bench scenarios can show the effects that build up over many cycles: the exact tick at which an event fires after a full reprogramming sequence, that limit, mode and enable survive a reset command, that ignored data truly has no effect, and that a match wins over an acknowledge issued in the same cycle.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  localparam int unsigned DATA_W = 32;

  localparam logic [7:0] OFF_CLR    = 8'h00;
  localparam logic [7:0] OFF_START  = 8'h04;
  localparam logic [7:0] OFF_STOP   = 8'h08;
  localparam logic [7:0] OFF_MODE   = 8'h0C;
  localparam logic [7:0] OFF_STAT   = 8'h10;
  localparam logic [7:0] OFF_COUNT  = 8'h14;
  localparam logic [7:0] OFF_LIMIT  = 8'h18;
  localparam logic [7:0] OFF_IRQEN  = 8'h1C;
  localparam logic [7:0] OFF_ACK    = 8'h20;

  localparam int unsigned ACK_BIT = 7;

  typedef enum logic [3:0] {
    RUN_IDLE   = 4'd1,
    RUN_ACTIVE = 4'd2
  } run_state_e;

  // Status word: pending, irq enable, one-shot, running, run code.
  function automatic logic [DATA_W-1:0] pack_status(input logic running,
                                                    input logic oneshot,
                                                    input logic irq_en,
                                                    input logic pending);
    run_state_e rs;
    rs = running ? RUN_ACTIVE : RUN_IDLE;
    return {{(DATA_W-8){1'b0}}, pending, irq_en, oneshot, running, rs};
  endfunction

endpackage

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             cmd_clr,
  input  logic             cmd_start,
  input  logic             cmd_stop,
  input  logic             ack_clr,
  input  logic             oneshot,
  input  logic [CNT_W-1:0] limit,
  output logic [CNT_W-1:0] cnt_q,
  output logic             run_q,
  output logic             pend_q,
  output logic             hit
);

  logic adv;

  // Next count after a qualified tick.
  function automatic logic [CNT_W-1:0] step_count(input logic [CNT_W-1:0] c,
                                                  input logic             at_lim,
                                                  input logic             os);
    if (!at_lim) return c + 1'b1;
    return os ? c : '0;
  endfunction

  assign adv = tick_en & run_q;
  assign hit = adv && (cnt_q == limit);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      run_q  <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      if (cmd_clr)  cnt_q <= '0;
      else if (adv) cnt_q <= step_count(cnt_q, hit, oneshot);

      if (cmd_stop)              run_q <= 1'b0;
      else if (cmd_start)        run_q <= 1'b1;
      else if (hit && oneshot)   run_q <= 1'b0;

      if (cmd_clr)      pend_q <= 1'b0;
      else if (hit)     pend_q <= 1'b1;
      else if (ack_clr) pend_q <= 1'b0;
    end
  end

  // R4 R5
  hit_sets_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !cmd_clr) |=> pend_q);

  // R4
  cont_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !oneshot && !cmd_clr) |=> (cnt_q == '0));

  // R5
  oneshot_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && oneshot && !cmd_clr && !cmd_start && !cmd_stop) |=> (!run_q && $stable(cnt_q)));

  // R3
  hold_no_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv && !cmd_clr) |=> $stable(cnt_q));

  // R2
  clr_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_clr |=> (cnt_q == '0 && !pend_q));

  // R8
  ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_clr && !hit) |=> !pend_q);

endmodule

// File: rtl/tmr_bus_if.sv
module tmr_bus_if
  import tmr_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_rd,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [CNT_W-1:0]  cnt_q,
  input  logic              run_q,
  input  logic              pend_q,
  output logic              cmd_clr,
  output logic              cmd_start,
  output logic              cmd_stop,
  output logic              ack_clr,
  output logic              oneshot_q,
  output logic              irqen_q,
  output logic [CNT_W-1:0]  limit_q
);

  logic [DATA_W-1:0] cnt_rd;
  logic [DATA_W-1:0] lim_rd;

  function automatic logic at(input logic [ADDR_W-1:0] a, input logic [7:0] off);
    return a == ADDR_W'(off);
  endfunction

  assign cmd_clr   = bus_wr && at(bus_addr, OFF_CLR);
  assign cmd_start = bus_wr && at(bus_addr, OFF_START);
  assign cmd_stop  = bus_wr && at(bus_addr, OFF_STOP);
  assign ack_clr   = bus_wr && at(bus_addr, OFF_ACK) && bus_wdata[ACK_BIT];

  generate
    if (CNT_W < DATA_W) begin : g_pad
      assign cnt_rd = {{(DATA_W-CNT_W){1'b0}}, cnt_q};
      assign lim_rd = {{(DATA_W-CNT_W){1'b0}}, limit_q};
    end else begin : g_full
      assign cnt_rd = cnt_q;
      assign lim_rd = limit_q;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      oneshot_q <= 1'b0;
      irqen_q   <= 1'b0;
      limit_q   <= '0;
    end else if (bus_wr) begin
      if (at(bus_addr, OFF_MODE))  oneshot_q <= bus_wdata[0];
      if (at(bus_addr, OFF_IRQEN)) irqen_q   <= bus_wdata[0];
      if (at(bus_addr, OFF_LIMIT)) limit_q   <= bus_wdata[CNT_W-1:0];
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      if (at(bus_addr, OFF_STAT))       bus_rdata = pack_status(run_q, oneshot_q, irqen_q, pend_q);
      else if (at(bus_addr, OFF_COUNT)) bus_rdata = cnt_rd;
      else if (at(bus_addr, OFF_LIMIT)) bus_rdata = lim_rd;
    end
  end

  // R9
  wo_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && (at(bus_addr, OFF_CLR) || at(bus_addr, OFF_START) || at(bus_addr, OFF_STOP) ||
                at(bus_addr, OFF_MODE) || at(bus_addr, OFF_IRQEN) || at(bus_addr, OFF_ACK)))
    |-> (bus_rdata == '0));

endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_rd,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);

  logic             cmd_clr, cmd_start, cmd_stop, ack_clr;
  logic             oneshot_q, irqen_q, run_q, pend_q, hit;
  logic [CNT_W-1:0] limit_q, cnt_q;

  tmr_bus_if #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_bus (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_rd    (bus_rd),
    .bus_rdata (bus_rdata),
    .cnt_q     (cnt_q),
    .run_q     (run_q),
    .pend_q    (pend_q),
    .cmd_clr   (cmd_clr),
    .cmd_start (cmd_start),
    .cmd_stop  (cmd_stop),
    .ack_clr   (ack_clr),
    .oneshot_q (oneshot_q),
    .irqen_q   (irqen_q),
    .limit_q   (limit_q)
  );

  tmr_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_en   (tick_en),
    .cmd_clr   (cmd_clr),
    .cmd_start (cmd_start),
    .cmd_stop  (cmd_stop),
    .ack_clr   (ack_clr),
    .oneshot   (oneshot_q),
    .limit     (limit_q),
    .cnt_q     (cnt_q),
    .run_q     (run_q),
    .pend_q    (pend_q),
    .hit       (hit)
  );

  assign irq = pend_q & irqen_q;

  // R7
  irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !irqen_q |-> !irq);

endmodule

// File: tb/tmr_channel_tb.sv
module tmr_channel_tb;

  localparam time CLK_P = 10ns;

  typedef struct {
    logic [31:0] exp;
    string       tag;
  } rd_item_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_rdata;
  logic        irq;

  int checks = 0;
  int failures = 0;
  rd_item_t exp_q[$];

  always #(CLK_P/2) clk = ~clk;

  tmr_channel u_dut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rd(bus_rd),
    .bus_rdata(bus_rdata), .irq(irq)
  );

  // Expected status word, built from the field list of R6.
  function automatic logic [31:0] st(input logic run, input logic os,
                                     input logic ie, input logic pend);
    logic [31:0] w;
    w = 32'h0;
    w[3:0] = run ? 4'h2 : 4'h1;
    w[4] = run;
    w[5] = os;
    w[6] = ie;
    w[7] = pend;
    return w;
  endfunction

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic wr_tick(input logic [7:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d; tick_en = 1'b1;
    @(posedge clk); #1;
    bus_wr = 1'b0; tick_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] e, input string tag);
    rd_item_t it;
    @(posedge clk); #1;
    it.exp = e; it.tag = tag;
    exp_q.push_back(it);
    bus_rd = 1'b1; bus_addr = a;
    @(posedge clk); #1;
    bus_rd = 1'b0;
  endtask

  task automatic ticks(input int n);
    @(posedge clk); #1;
    tick_en = 1'b1;
    repeat (n) @(posedge clk);
    #1 tick_en = 1'b0;
  endtask

  task automatic chk_irq(input logic e, input string tag);
    checks++;
    if (irq !== e) begin
      failures++;
      $display("FAIL %s irq actual=%0b expected=%0b", tag, irq, e);
    end
  endtask

  // Monitor: compare every read against the next expected item.
  always @(negedge clk) begin
    if (bus_rd) begin
      checks++;
      if (exp_q.size() == 0) begin
        failures++;
        $display("FAIL scoreboard empty actual=%h expected=none", bus_rdata);
      end else begin
        rd_item_t it;
        it = exp_q.pop_front();
        if (bus_rdata !== it.exp) begin
          failures++;
          $display("FAIL %s actual=%h expected=%h", it.tag, bus_rdata, it.exp);
        end
      end
    end
  end

  task automatic rearm(input logic [31:0] lim);
    wr(8'h1C, 32'h0);
    wr(8'h08, 32'h0);
    wr(8'h00, 32'h0);
    wr(8'h18, lim);
    wr(8'h0C, 32'h1);
    wr(8'h1C, 32'h1);
    wr(8'h04, 32'h0);
  endtask

  initial begin
    #(CLK_P * 100000);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    rd(8'h10, st(0, 0, 0, 0), "R1 status");
    rd(8'h14, 32'd0, "R1 count");
    rd(8'h18, 32'd0, "R1 limit");
    chk_irq(1'b0, "R1");

    // Continuous setup; start with junk data (R2)
    wr(8'h18, 32'd3);
    wr(8'h1C, 32'h1);
    wr(8'h0C, 32'h0);
    wr(8'h04, 32'hDEADBEEF);
    rd(8'h10, st(1, 0, 1, 0), "R6 running status");

    // R3 counting only on qualified ticks
    ticks(2);
    rd(8'h14, 32'd2, "R3 count after two ticks");
    repeat (3) @(posedge clk);
    rd(8'h14, 32'd2, "R3 hold without tick");

    // R4 match and wrap
    ticks(1);
    rd(8'h10, st(1, 0, 1, 0), "R4 no pend before match");
    ticks(1);
    rd(8'h14, 32'd0, "R4 wrap to zero");
    rd(8'h10, st(1, 0, 1, 1), "R4 pending set");
    chk_irq(1'b1, "R7 irq asserted");

    // R7 mask
    wr(8'h1C, 32'h0);
    chk_irq(1'b0, "R7 masked");
    rd(8'h10, st(1, 0, 0, 1), "R7 pend kept when masked");
    wr(8'h1C, 32'h1);
    chk_irq(1'b1, "R7 unmasked");

    // R8 acknowledge
    wr(8'h20, 32'h7F);
    rd(8'h10, st(1, 0, 1, 1), "R8 ack without bit7 ignored");
    wr(8'h20, 32'h80);
    rd(8'h10, st(1, 0, 1, 0), "R8 ack clears");
    chk_irq(1'b0, "R8 irq dropped");

    // R4 repeats every limit+1 ticks
    ticks(3);
    rd(8'h10, st(1, 0, 1, 0), "R4 second period not yet");
    ticks(1);
    rd(8'h10, st(1, 0, 1, 1), "R4 fires again");
    wr(8'h20, 32'h80);

    // R8 match wins over simultaneous ack
    ticks(3);
    rd(8'h14, 32'd3, "R8 count at limit");
    wr_tick(8'h20, 32'h80);
    rd(8'h10, st(1, 0, 1, 1), "R8 set wins over ack");
    rd(8'h14, 32'd0, "R4 wrap during ack");
    wr(8'h20, 32'h80);

    // R2 stop with junk data freezes count
    ticks(2);
    wr(8'h08, 32'hFFFFFFFF);
    ticks(5);
    rd(8'h14, 32'd2, "R2 stopped count holds");
    rd(8'h10, st(0, 0, 1, 0), "R2 stopped status");

    // R2 clear command with pending flag set
    wr(8'h04, 32'h0);
    ticks(2);
    ticks(1);
    wr(8'h08, 32'h0);
    rd(8'h10, st(0, 0, 1, 1), "R2 pending before clear");
    rd(8'h14, 32'd1, "R2 count before clear");
    wr(8'h00, 32'h1234);
    rd(8'h14, 32'd0, "R2 clear zeroes count");
    rd(8'h10, st(0, 0, 1, 0), "R2 clear drops pend keeps ie");
    rd(8'h18, 32'd3, "R2 limit retained");

    // R9 write-only and unmapped offsets read zero
    rd(8'h00, 32'd0, "R9 read clr");
    rd(8'h04, 32'd0, "R9 read start");
    rd(8'h08, 32'd0, "R9 read stop");
    rd(8'h0C, 32'd0, "R9 read mode");
    rd(8'h1C, 32'd0, "R9 read irqen");
    rd(8'h20, 32'd0, "R9 read ack");
    rd(8'h24, 32'd0, "R9 read unmapped");

    // R10 reprogramming sequence, one-shot (R5)
    rearm(32'd5);
    rd(8'h10, st(1, 1, 1, 0), "R10 armed status");
    rd(8'h14, 32'd0, "R10 armed count");
    ticks(5);
    rd(8'h10, st(1, 1, 1, 0), "R10 no event before limit+1");
    ticks(1);
    rd(8'h10, st(0, 1, 1, 1), "R5 one-shot fired and idle");
    rd(8'h14, 32'd5, "R5 count held at limit");
    chk_irq(1'b1, "R5 irq");
    ticks(3);
    rd(8'h14, 32'd5, "R5 further ticks ignored");

    // R10 rearm from a fired state
    rearm(32'd2);
    rd(8'h10, st(1, 1, 1, 0), "R10 rearm clears pend");
    chk_irq(1'b0, "R10 irq low after rearm");
    ticks(2);
    rd(8'h10, st(1, 1, 1, 0), "R10 second event not yet");
    ticks(1);
    rd(8'h10, st(0, 1, 1, 1), "R10 second event fired");
    rd(8'h14, 32'd2, "R5 second hold");

    repeat (3) @(posedge clk);
    if (exp_q.size() != 0) begin
      failures++;
      checks++;
      $display("FAIL scoreboard leftover actual=%0d expected=0", exp_q.size());
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule